// File: doc/BRIEF.md
# Lockable Watchdog Timer with Power-of-Two Prescaler

The block supervises software through a two-stage counting chain. The first stage is an 8-bit prescaler whose division ratio is picked by a 3-bit code. The second stage is a timer of `TMR_W` bits, 15 by default, that advances once per prescaler period. Software arms the watchdog with a register write. It must then restart the timer periodically by writing the kick bit. If the timer runs past its last count, the block raises a one-cycle reset request. It also records that event in a cause flag. The rest of the chip uses that pulse to reset the device.

Arming cannot be undone by software. Only the synchronous reset or the power-on reset returns the block to the unarmed state, as does the watchdog's own expiry. A configuration bit chooses whether both counters keep running while the device reports idle. The cause flag is not affected by the ordinary reset, so software can read it after the reset the watchdog itself triggered. A power-on reset clears it, and so does a software write of 0 to its bit.

All pins are plain control and status signals; the block has no data stream, so no valid/ready handshake applies. The control word is 7 bits wide and uses the same layout for writes and reads:

| Bit | Field | Write | Read |
|-----|-------|-------|------|
| 0 | arm | 1 arms; 0 has no effect | 1 while armed |
| 1 | kick | 1 restarts both counters (only while armed) | always 0 |
| 2 | idle_run | 1: count while idle, 0: freeze while idle | stored value |
| 5:3 | div | prescale code n, ratio 2^(n+1) | stored value |
| 6 | cause | 0 clears the flag; 1 leaves it unchanged | 1 after a watchdog expiry |

Top module: `wdog_guard`

## Requirements
- R1: While `rst` or `por` is high, `bark` is 0, and at the next cycle the read word shows arm=0, idle_run=0 and div=0. After a `por` the whole read word is 0.
- R2: A write with bit 0 set arms the watchdog, and the read word then shows bit 0 = 1.
- R3: A write with bit 0 clear, made while armed, leaves the watchdog armed. It also leaves the expiry time unchanged.
- R4: While armed and counting, the timer advances once every 2^(div+1) cycles. An unserviced watchdog pulses `bark` exactly 2^TMR_W * 2^(div+1) active cycles after the arming write's clock edge. This holds for codes 0, 2 and 7, for example.
- R5: A write with bit 1 set, made while armed, restarts the prescaler and the timer from zero. The next expiry is then a full period after the kick edge, and bit 1 always reads 0.
- R6: `bark` is high for exactly one cycle. In that same cycle the read word already shows arm=0, and both counters are back at zero.
- R7: The cause flag (bit 6) is set at expiry and keeps its value through `rst`. It is cleared by a write with bit 6 = 0 or by `por`. A write with bit 6 = 1 never sets it.
- R8: With idle_run=0, every cycle in which `idle` is high freezes both counters, which delays the expiry by that many cycles. With idle_run=1, `idle` has no effect on the expiry time.
- R9: While not armed, neither counter advances and `bark` stays 0.
- R10: A kick written on the very clock edge that would have been the overflow edge wins. No pulse is raised, and the next expiry falls a full period after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high; clears everything including the cause flag |
| rst | input | 1 | Synchronous reset, active high; clears everything except the cause flag |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 7 | Control word write value (layout above) |
| idle | input | 1 | Device idle indication |
| rd_data | output | 7 | Control word read value (layout above) |
| bark | output | 1 | One-cycle watchdog reset request |

## Verification
Corrupted prescaler or timer state shows up at only one place: the cycle in which `bark` rises. So every expiry is predicted to the exact cycle, and an early, late, missing or extra pulse is reported when it happens. A stored bit that is wrong, such as arm, the configuration or the cause flag, shows up in `rd_data` on the cycle after the write or event that set it, and the bench reads it back there. The idle freeze, the lock on disarming and the kick on the overflow edge can only be seen through the timing of `bark`. Each of them therefore gets its own predicted expiry cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // control word layout (shared by write and read)
  localparam int CW_W     = 7;
  localparam int B_ARM    = 0;
  localparam int B_KICK   = 1;
  localparam int B_IDLE   = 2;
  localparam int DIV_LSB  = 3;
  localparam int DIV_W    = 3;
  localparam int B_CAUSE  = 6;

  typedef struct packed {
    logic             idle_run;
    logic [DIV_W-1:0] div;
  } wdg_cfg_t;

  localparam wdg_cfg_t CFG_RST = '{idle_run: 1'b0, div: '0};
endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
  parameter int SEL_W = 3,
  localparam int PRE_W = 1 << SEL_W,
  localparam int N_SEL = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick,
  output logic [PRE_W-1:0] cnt
);
  logic [N_SEL-1:0] at_top;

  // code c completes a period when the low c+1 bits are all ones
  for (genvar c = 0; c < N_SEL; c++) begin : g_top
    assign at_top[c] = &cnt[c:0];
  end

  assign tick = run & at_top[sel];

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (run)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer #(
  parameter int TMR_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  output logic             wrap,
  output logic [TMR_W-1:0] cnt
);
  assign wrap = tick & (&cnt);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
(
  input  logic            clk,
  input  logic            por,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [CW_W-1:0] wr_data,
  input  logic            fire,
  output logic            armed,
  output wdg_cfg_t        cfg,
  output logic            kick,
  output logic            cause,
  output logic            req
);
  logic hard_rst;
  assign hard_rst = por | rst;

  // kick is a strobe: never stored, so it reads back as zero
  assign kick = armed & wr_en & wr_data[B_KICK];

  always_ff @(posedge clk) begin
    if (hard_rst)                     armed <= 1'b0;
    else if (fire)                    armed <= 1'b0;
    else if (wr_en && wr_data[B_ARM]) armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (hard_rst) cfg <= CFG_RST;
    else if (wr_en) begin
      cfg.idle_run <= wr_data[B_IDLE];
      cfg.div      <= wr_data[DIV_LSB +: DIV_W];
    end
  end

  // survives rst; only por or a software write of zero clears it
  always_ff @(posedge clk) begin
    if (por)                             cause <= 1'b0;
    else if (fire)                       cause <= 1'b1;
    else if (wr_en && !wr_data[B_CAUSE]) cause <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (hard_rst) req <= 1'b0;
    else          req <= fire;
  end
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdg_pkg::*;
#(
  parameter int TMR_W = 15,
  localparam int PRE_W = 1 << DIV_W
) (
  input  logic            clk,
  input  logic            por,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [CW_W-1:0] wr_data,
  input  logic            idle,
  output logic [CW_W-1:0] rd_data,
  output logic            bark
);
  logic             armed, kick, cause, wrap, fire, tick, run, cnt_clr, hard_rst;
  wdg_cfg_t         cfg;
  logic [PRE_W-1:0] pre_cnt;
  logic [TMR_W-1:0] tmr_cnt;

  assign hard_rst = por | rst;
  // a kick on the overflow edge rescues the device
  assign fire     = wrap & ~kick;
  assign run      = armed & (cfg.idle_run | ~idle);
  assign cnt_clr  = ~armed | kick | fire;

  wdg_ctrl u_ctrl (
    .clk(clk), .por(por), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .fire(fire), .armed(armed), .cfg(cfg), .kick(kick), .cause(cause), .req(bark)
  );

  wdg_prescale #(.SEL_W(DIV_W)) u_pre (
    .clk(clk), .rst(hard_rst), .clr(cnt_clr), .run(run), .sel(cfg.div),
    .tick(tick), .cnt(pre_cnt)
  );

  wdg_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst(hard_rst), .clr(cnt_clr), .tick(tick),
    .wrap(wrap), .cnt(tmr_cnt)
  );

  always_comb begin
    rd_data                     = '0;
    rd_data[B_ARM]              = armed;
    rd_data[B_IDLE]             = cfg.idle_run;
    rd_data[DIV_LSB +: DIV_W]   = cfg.div;
    rd_data[B_CAUSE]            = cause;
  end
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk
  import wdg_pkg::*;
#(
  parameter int TMR_W = 15,
  parameter int PRE_W = 8
) (
  input logic            clk,
  input logic            por,
  input logic            rst,
  input logic            wr_en,
  input logic [CW_W-1:0] wr_data,
  input logic            idle,
  input logic [CW_W-1:0] rd_data,
  input logic            bark,
  input logic [TMR_W-1:0] tmr,
  input logic [PRE_W-1:0] presc
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (por)
    rst |=> (!bark && !rd_data[B_ARM]));
  // R6
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (por || rst)
    bark |=> !bark);
  // R6
  a_r6_disarm_on_pulse: assert property (@(posedge clk) disable iff (por || rst)
    bark |-> (!rd_data[B_ARM] && tmr == '0 && presc == '0));
  // R7
  a_r7_cause_on_pulse: assert property (@(posedge clk) disable iff (por || rst)
    bark |-> rd_data[B_CAUSE]);
  // R3
  a_r3_no_disarm: assert property (@(posedge clk) disable iff (por || rst)
    rd_data[B_ARM] |=> (rd_data[B_ARM] || bark));
  // R9
  a_r9_quiet_unarmed: assert property (@(posedge clk) disable iff (por || rst)
    !rd_data[B_ARM] |=> (!bark && tmr == '0));
  // R5
  a_r5_kick_restarts: assert property (@(posedge clk) disable iff (por || rst)
    (rd_data[B_ARM] && wr_en && wr_data[B_KICK]) |=> (tmr == '0 && presc == '0));
  // R8
  a_r8_idle_freeze: assert property (@(posedge clk) disable iff (por || rst)
    (rd_data[B_ARM] && idle && !rd_data[B_IDLE] && !(wr_en && wr_data[B_KICK]))
      |=> ($stable(tmr) && $stable(presc)));
endmodule

bind wdog_guard wdog_guard_chk #(.TMR_W(TMR_W), .PRE_W(PRE_W)) i_chk (
  .clk(clk), .por(por), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .idle(idle), .rd_data(rd_data), .bark(bark), .tmr(tmr_cnt), .presc(pre_cnt)
);

// File: tb/test_wdog_guard.sv
module test_wdog_guard;
  localparam int TW = 8;
  localparam int BASE = 1 << TW;

  logic       clk = 1'b0;
  logic       por = 1'b1, rst = 1'b1, wr_en = 1'b0, idle = 1'b0;
  logic [6:0] wr_data = '0;
  logic [6:0] rd_data;
  logic       bark;

  int unsigned cyc = 0;
  int unsigned n_vec = 0, n_bad = 0, n_pulse = 0;
  int unsigned exp_q[$];
  bit done = 0;

  wdog_guard #(.TMR_W(TW)) i_wdog_guard (
    .clk(clk), .por(por), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .idle(idle), .rd_data(rd_data), .bark(bark)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int unsigned act, input int unsigned expv);
    n_vec++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // monitor: each pulse must match the head of the expectation queue
  always @(negedge clk) begin
    if (!por && !rst && bark) begin
      n_pulse++;
      if (exp_q.size() == 0) chk("R4 stray pulse", cyc, 0);
      else chk("R4 pulse cycle", cyc, exp_q.pop_front());
    end
  end

  // write on the edge numbered 'edge_no' (0 = next edge)
  task automatic wr_at(input int unsigned edge_no, input logic [6:0] d, output int unsigned e);
    @(negedge clk);
    while (edge_no != 0 && cyc + 1 < edge_no) @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    e = cyc;
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wr(input logic [6:0] d, output int unsigned e);
    wr_at(0, d, e);
  endtask

  task automatic drain(input string req, input int unsigned limit);
    int unsigned n = 0;
    while (exp_q.size() != 0 && n < limit) begin @(negedge clk); n++; end
    chk(req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic do_rst();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic idle_window(input int unsigned start, input int unsigned len);
    while (cyc + 1 < start) @(negedge clk);
    idle = 1'b1;
    while (cyc + 1 < start + len) @(negedge clk);
    idle = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned e, k, p0;
    repeat (3) @(negedge clk);
    por = 1'b0; rst = 1'b0;
    @(negedge clk);
    chk("R1 read after por", rd_data, 7'h00);
    chk("R1 bark idle", bark, 0);

    // R2/R3/R4/R6/R7/R9: divide code 0
    wr(7'h41, e);
    exp_q.push_back(e + 2 * BASE);
    chk("R2 armed readback", rd_data, 7'h01);
    repeat (100) @(negedge clk);
    wr(7'h40, k);
    chk("R3 still armed", rd_data[0], 1);
    drain("R4 code0 expiry", 3 * BASE);
    chk("R6 disarmed and R7 cause set", rd_data, 7'h40);
    p0 = n_pulse;
    repeat (1500) @(negedge clk);
    chk("R9 no pulse while unarmed", n_pulse, p0);

    // R7 survives rst, cleared by write of zero
    do_rst();
    chk("R7 cause survives rst", rd_data, 7'h40);
    wr(7'h00, k);
    chk("R7 cause cleared", rd_data, 7'h00);

    // R5: kick with code 2
    wr(7'h51, e);
    chk("R2 armed code2", rd_data, 7'h11);
    wr_at(e + 1000, 7'h52, k);
    chk("R5 kick reads zero", rd_data, 7'h11);
    exp_q.push_back(k + 8 * BASE);
    drain("R5 expiry after kick", 10 * BASE);
    chk("R7 cause after kick expiry", rd_data, 7'h50);

    // R10: kick on the overflow edge
    do_rst();
    wr(7'h00, k);
    wr(7'h41, e);
    wr_at(e + 2 * BASE, 7'h42, k);
    chk("R10 kick edge", k, e + 2 * BASE);
    exp_q.push_back(k + 2 * BASE);
    drain("R10 rescued then expiry", 5 * BASE);

    // R8: freeze while idle
    do_rst();
    wr(7'h00, k);
    wr(7'h41, e);
    idle_window(e + 50, 100);
    exp_q.push_back(e + 2 * BASE + 100);
    drain("R8 frozen expiry", 4 * BASE);

    // R8: count while idle
    do_rst();
    wr(7'h00, k);
    wr(7'h45, e);
    chk("R8 idle_run readback", rd_data, 7'h05);
    idle_window(e + 50, 100);
    exp_q.push_back(e + 2 * BASE);
    drain("R8 idle_run expiry", 4 * BASE);

    // R4: code 7, R7 write of one leaves flag
    do_rst();
    wr(7'h79, e);
    chk("R4 code7 readback", rd_data, 7'h79);
    exp_q.push_back(e + 256 * BASE);
    drain("R4 code7 expiry", 258 * BASE);
    chk("R6 after code7 expiry", rd_data, 7'h78);

    // R1: por clears everything
    @(negedge clk); por = 1'b1;
    @(negedge clk); por = 1'b0;
    chk("R1 por clears cause", rd_data, 7'h00);

    finish_run();
  end
endmodule